// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

This block is a byte-wide static RAM in which every word has a nonvolatile shadow copy. Host logic uses an ordinary SRAM-style port: active-low chip enable, output enable and write enable, an address and a bidirectional data bus. The port is sampled on the rising clock edge. Reads drive the addressed working word onto the bus without a clock delay. Writes take effect at the edge.

Besides normal access, the block moves data between its two arrays. A STORE copies the working array into the shadow array. A RECALL first clears the working array and then loads it from the shadow array. The following events start a transfer:

- a power-down pulse starts a STORE;
- a power-up pulse starts a RECALL;
- a falling edge on the store request pin starts a STORE;
- an unlock sequence of six reads starts a STORE or a RECALL, depending on the sixth address.

Only one word moves per clock. While a transfer runs, the block drives a busy indication and locks out host accesses. There is no streaming data path, so no valid/ready handshake exists. Host accesses are single-cycle and are never stalled; during a transfer they are simply ignored.

Top module: `nv_shadow_ram`

## Requirements
- R1: After reset, every word of both arrays reads zero, `busy` is 0 and `busy_n` is 1.
- R2: While idle, a cycle with `ce_n`=0 and `we_n`=0 writes `dq` into word `addr` at the clock edge. With `ce_n`=0, `oe_n`=0 and `we_n`=1, `dq` carries word `addr`. In every other case `dq` is left undriven.
- R3: A one-cycle `pwr_dn` pulse while idle starts a STORE. `busy` is then 1 for exactly STORE_CYCLES cycles, beginning the cycle after the sampling edge. Afterwards every shadow word equals the working word as it stood when the pulse was sampled.
- R4: A `pwr_up` pulse while idle starts a RECALL. `busy` is 1 for exactly RECALL_CYCLES cycles. Afterwards every working word equals its shadow word. A RECALL never changes the shadow array.
- R5: A RECALL spends its first busy cycle clearing the whole working array to zero. It then loads shadow word j at the (j+2)-th edge after the start edge.
- R6: A falling edge of `store_n` while idle starts a STORE, the same as R3. Holding `store_n` low afterwards starts nothing more.
- R7: Six consecutive single-cycle reads to word addresses 0x0E, 0x11, 0x03, 0x1C, 0x07 and then 0x1F start a STORE at the sixth read's edge.
- R8: The same first five reads followed by a read of 0x0C start a RECALL.
- R9: Any write, or any read to an address other than the next expected step, aborts the unlock sequence. A read of 0x0E begins a new sequence at step one. An aborted sequence starts no transfer, and a complete sequence after it does.
- R10: While busy, host writes are ignored and `dq` is not driven. `pwr_up`, `store_n` and unlock requests are dropped, except as stated in R11. During a STORE the working array does not change.
- R11: `pwr_dn` during a RECALL aborts it at that edge, without that edge's clear or load, and starts a full STORE of the working array in its partial state.
- R12: When `pwr_dn` and `pwr_up` arrive together while idle, the STORE wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; both arrays cleared |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Word address |
| dq | inout | DATA_W | Bidirectional data bus |
| store_n | input | 1 | Store request pin; a falling edge requests a STORE |
| pwr_up | input | 1 | Power-up event pulse, requests a RECALL |
| pwr_dn | input | 1 | Power-down event pulse, requests a STORE |
| busy_n | output | 1 | Busy indication, low during any transfer |
| busy | output | 1 | Busy status, high during any transfer |

## Verification
The working array is filled with several distinct arithmetic patterns: an affine byte ramp, a second ramp, and an XOR ramp. Each pattern is swept over all 32 words. Because the patterns differ word by word, a recall that returns a stale pattern, shifts an index or skips a word shows up as a mismatch. Overwriting the working array before every recall separates data that truly came from the shadow copy from leftovers. A recall cut short by a power-down leaves a boundary of loaded words followed by zeros, which pins down both the clear step and the load order. Interrupted unlock sequences, one broken by a write and one by a stray read, are compared with a complete sequence to show that only exact ordering triggers a transfer.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

  typedef enum logic [1:0] {
    X_IDLE     = 2'd0,
    X_STORE    = 2'd1,
    X_RCL_CLR  = 2'd2,
    X_RCL_LOAD = 2'd3
  } xfer_state_e;

  typedef enum logic [1:0] {
    OP_NONE      = 2'd0,
    OP_SAVE_WORD = 2'd1,
    OP_CLEAR_ALL = 2'd2,
    OP_LOAD_WORD = 2'd3
  } arr_op_e;

  typedef struct packed {
    logic pwr_dn;
    logic pwr_up;
    logic pin_store;
    logic sw_store;
    logic sw_recall;
  } xfer_req_t;

  localparam int unsigned PREFIX_LEN = 5;

endpackage

// File: rtl/nvs_seq_detect.sv
module nvs_seq_detect
  import nvs_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter logic [PREFIX_LEN-1:0][ADDR_W-1:0] PREFIX_ADDRS =
    {5'h07, 5'h1C, 5'h03, 5'h11, 5'h0E},
  parameter logic [ADDR_W-1:0] STORE_ADDR  = 5'h1F,
  parameter logic [ADDR_W-1:0] RECALL_ADDR = 5'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blocked,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              sw_store,
  output logic              sw_recall
);

  localparam int unsigned STEP_W = $clog2(PREFIX_LEN + 1);

  logic [STEP_W-1:0] step;
  logic [ADDR_W-1:0] expect_addr;
  logic              at_final;
  logic              is_read;

  // Address expected for the current prefix step
  always_comb begin
    expect_addr = PREFIX_ADDRS[0];
    for (int i = 0; i < PREFIX_LEN; i++) begin
      if (step == STEP_W'(i)) expect_addr = PREFIX_ADDRS[i];
    end
  end

  assign at_final  = (step == STEP_W'(PREFIX_LEN));
  assign is_read   = acc_valid && !acc_write && !blocked;
  assign sw_store  = is_read && at_final && (acc_addr == STORE_ADDR);
  assign sw_recall = is_read && at_final && (acc_addr == RECALL_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= '0;
    end else if (blocked) begin
      step <= '0;
    end else if (acc_valid) begin
      if (!acc_write && !at_final && acc_addr == expect_addr) begin
        step <= step + 1'b1;
      end else if (!acc_write && acc_addr == PREFIX_ADDRS[0]) begin
        step <= STEP_W'(1);
      end else begin
        step <= '0;
      end
    end
  end

endmodule

// File: rtl/nvs_xfer_engine.sv
module nvs_xfer_engine
  import nvs_pkg::*;
#(
  parameter int unsigned DEPTH         = 32,
  parameter int unsigned STORE_CYCLES  = 48,
  parameter int unsigned RECALL_CYCLES = 40,
  localparam int unsigned IDX_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(STORE_CYCLES + RECALL_CYCLES + DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  xfer_req_t        req,
  output xfer_state_e      xstate,
  output arr_op_e          arr_op,
  output logic [IDX_W-1:0] arr_idx,
  output logic             busy
);

  logic [CNT_W-1:0] cnt;
  logic             in_window;
  logic             store_start;
  logic             recall_start;

  assign in_window    = (cnt < CNT_W'(DEPTH));
  assign store_start  = req.pwr_dn || req.pin_store || req.sw_store;
  assign recall_start = req.pwr_up || req.sw_recall;
  assign busy         = (xstate != X_IDLE);
  assign arr_idx      = cnt[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xstate <= X_IDLE;
      cnt    <= '0;
    end else begin
      unique case (xstate)
        X_IDLE: begin
          cnt <= '0;
          if (store_start)       xstate <= X_STORE;
          else if (recall_start) xstate <= X_RCL_CLR;
        end
        X_STORE: begin
          if (cnt == CNT_W'(STORE_CYCLES - 1)) begin
            xstate <= X_IDLE;
            cnt    <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        X_RCL_CLR: begin
          cnt <= '0;
          if (req.pwr_dn) xstate <= X_STORE;
          else            xstate <= X_RCL_LOAD;
        end
        X_RCL_LOAD: begin
          if (req.pwr_dn) begin
            xstate <= X_STORE;
            cnt    <= '0;
          end else if (cnt == CNT_W'(RECALL_CYCLES - 2)) begin
            xstate <= X_IDLE;
            cnt    <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          xstate <= X_IDLE;
          cnt    <= '0;
        end
      endcase
    end
  end

  always_comb begin
    arr_op = OP_NONE;
    unique case (xstate)
      X_STORE:    if (in_window) arr_op = OP_SAVE_WORD;
      X_RCL_CLR:  if (!req.pwr_dn) arr_op = OP_CLEAR_ALL;
      X_RCL_LOAD: if (!req.pwr_dn && in_window) arr_op = OP_LOAD_WORD;
      default:    arr_op = OP_NONE;
    endcase
  end

endmodule

// File: rtl/nvs_arrays.sv
module nvs_arrays
  import nvs_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         usr_we,
  input  logic [IDX_W-1:0]             usr_idx,
  input  logic [DATA_W-1:0]            usr_wdata,
  input  arr_op_e                      op,
  input  logic [IDX_W-1:0]             op_idx,
  output logic [DEPTH-1:0][DATA_W-1:0] work_q,
  output logic [DEPTH-1:0][DATA_W-1:0] shadow_q
);

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic hit_op;
    logic hit_usr;

    assign hit_op  = (op_idx == IDX_W'(w));
    assign hit_usr = usr_we && (usr_idx == IDX_W'(w));

    // Working word: transfer operations take precedence over host writes
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        work_q[w] <= '0;
      end else if (op == OP_CLEAR_ALL) begin
        work_q[w] <= '0;
      end else if (op == OP_LOAD_WORD && hit_op) begin
        work_q[w] <= shadow_q[w];
      end else if (hit_usr) begin
        work_q[w] <= usr_wdata;
      end
    end

    // Shadow word: only a store step may change it
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q[w] <= '0;
      end else if (op == OP_SAVE_WORD && hit_op) begin
        shadow_q[w] <= work_q[w];
      end
    end
  end

endmodule

// File: rtl/nv_shadow_ram.sv
module nv_shadow_ram
  import nvs_pkg::*;
#(
  parameter int unsigned ADDR_W        = 5,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned STORE_CYCLES  = 48,
  parameter int unsigned RECALL_CYCLES = 40,
  parameter logic [PREFIX_LEN-1:0][ADDR_W-1:0] PREFIX_ADDRS =
    {5'h07, 5'h1C, 5'h03, 5'h11, 5'h0E},
  parameter logic [ADDR_W-1:0] STORE_ADDR  = 5'h1F,
  parameter logic [ADDR_W-1:0] RECALL_ADDR = 5'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DATA_W-1:0] dq,
  input  logic              store_n,
  input  logic              pwr_up,
  input  logic              pwr_dn,
  output logic              busy_n,
  output logic              busy
);

  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic                         store_n_q;
  logic                         pin_store;
  logic                         sw_store;
  logic                         sw_recall;
  logic                         usr_we;
  logic                         rd_drive;
  xfer_req_t                    req;
  xfer_state_e                  xstate;
  arr_op_e                      arr_op;
  logic [IDX_W-1:0]             arr_idx;
  logic [DEPTH-1:0][DATA_W-1:0] work_q;
  logic [DEPTH-1:0][DATA_W-1:0] shadow_q;

  // Falling-edge detect on the store request pin
  always_ff @(posedge clk) begin
    if (!rst_n) store_n_q <= 1'b1;
    else        store_n_q <= store_n;
  end
  assign pin_store = store_n_q && !store_n;

  assign req = '{pwr_dn:    pwr_dn,
                 pwr_up:    pwr_up,
                 pin_store: pin_store,
                 sw_store:  sw_store,
                 sw_recall: sw_recall};

  nvs_seq_detect #(
    .ADDR_W      (ADDR_W),
    .PREFIX_ADDRS(PREFIX_ADDRS),
    .STORE_ADDR  (STORE_ADDR),
    .RECALL_ADDR (RECALL_ADDR)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .blocked  (busy),
    .acc_valid(!ce_n),
    .acc_write(!we_n),
    .acc_addr (addr),
    .sw_store (sw_store),
    .sw_recall(sw_recall)
  );

  nvs_xfer_engine #(
    .DEPTH        (DEPTH),
    .STORE_CYCLES (STORE_CYCLES),
    .RECALL_CYCLES(RECALL_CYCLES)
  ) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (req),
    .xstate (xstate),
    .arr_op (arr_op),
    .arr_idx(arr_idx),
    .busy   (busy)
  );

  assign usr_we = !ce_n && !we_n && !busy;

  nvs_arrays #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W)
  ) u_arrays (
    .clk      (clk),
    .rst_n    (rst_n),
    .usr_we   (usr_we),
    .usr_idx  (addr),
    .usr_wdata(dq),
    .op       (arr_op),
    .op_idx   (arr_idx),
    .work_q   (work_q),
    .shadow_q (shadow_q)
  );

  assign rd_drive = !ce_n && !oe_n && we_n && !busy;
  assign dq       = rd_drive ? work_q[addr] : {DATA_W{1'bz}};
  assign busy_n   = !busy;

endmodule

// File: rtl/nvs_checker.sv
module nvs_checker
  import nvs_pkg::*;
#(
  parameter int unsigned DEPTH        = 32,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned STORE_CYCLES = 48
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         busy,
  input logic                         pwr_dn,
  input logic                         pwr_up,
  input logic                         pin_store,
  input logic                         sw_store,
  input logic                         sw_recall,
  input xfer_state_e                  xstate,
  input logic [DEPTH-1:0][DATA_W-1:0] work_q,
  input logic [DEPTH-1:0][DATA_W-1:0] shadow_q
);

  localparam int unsigned RUN_W = $clog2(STORE_CYCLES + 2);

  logic [RUN_W-1:0] store_run;
  logic             in_store;
  logic             in_recall;

  assign in_store  = (xstate == X_STORE);
  assign in_recall = (xstate == X_RCL_CLR) || (xstate == X_RCL_LOAD);

  always_ff @(posedge clk) begin
    if (!rst_n)        store_run <= '0;
    else if (in_store) store_run <= store_run + 1'b1;
    else               store_run <= '0;
  end

  AST_START_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pwr_dn || pwr_up || pin_store || sw_store || sw_recall)); // R7

  AST_STORE_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_store) |-> (store_run == RUN_W'(STORE_CYCLES))); // R3

  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_store |=> $stable(shadow_q)); // R4

  AST_WORK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    in_store |=> $stable(work_q)); // R10

  AST_PREEMPT_RECALL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_recall && pwr_dn) |=> in_store); // R11

  AST_DOWN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (xstate == X_IDLE && pwr_dn && pwr_up) |=> in_store); // R12

endmodule

bind nv_shadow_ram nvs_checker #(
  .DEPTH       (DEPTH),
  .DATA_W      (DATA_W),
  .STORE_CYCLES(STORE_CYCLES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .pwr_dn   (pwr_dn),
  .pwr_up   (pwr_up),
  .pin_store(pin_store),
  .sw_store (sw_store),
  .sw_recall(sw_recall),
  .xstate   (xstate),
  .work_q   (work_q),
  .shadow_q (shadow_q)
);

// File: tb/nv_shadow_ram_test.sv
`timescale 1ns/1ps
module nv_shadow_ram_test;

  localparam int AW    = 5;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam int SCYC  = 48;
  localparam int RCYC  = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          store_n = 1'b1;
  logic          pwr_up = 1'b0;
  logic          pwr_dn = 1'b0;
  logic          drv = 1'b0;
  logic [DW-1:0] dval = '0;
  wire  [DW-1:0] dq;
  logic          busy_n;
  logic          busy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  assign dq = drv ? dval : {DW{1'bz}};

  always #2.5 clk = ~clk;

  nv_shadow_ram uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq(dq), .store_n(store_n), .pwr_up(pwr_up),
    .pwr_dn(pwr_dn), .busy_n(busy_n), .busy(busy)
  );

  function automatic logic [DW-1:0] pat(input int kind, input int i);
    case (kind)
      0: return DW'(i * 37 + 5);
      1: return DW'(i * 11 + 8'hA0);
      2: return DW'(i ^ 8'h3C);
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    ce_n = 1'b0; we_n = 1'b0; addr = AW'(a); drv = 1'b1; dval = d;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; drv = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = AW'(a);
    @(negedge clk);
    d = dq;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic fill(input int kind);
    for (int i = 0; i < DEPTH; i++) wr(i, pat(kind, i));
  endtask

  task automatic verify(input string req, input int kind);
    logic [DW-1:0] d;
    for (int i = 0; i < DEPTH; i++) begin
      rd(i, d);
      check(req, d, pat(kind, i));
    end
  endtask

  // Counts negedges with busy high, starting at the current negedge
  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic pulse(input logic dn, input logic up, output int n);
    pwr_dn = dn; pwr_up = up;
    @(negedge clk);
    pwr_dn = 1'b0; pwr_up = 1'b0;
    busy_len(n);
  endtask

  task automatic seq(input int last, input int cut_after, input int cut_kind);
    logic [DW-1:0] d;
    int a[5] = '{5'h0E, 5'h11, 5'h03, 5'h1C, 5'h07};
    for (int k = 0; k < 5; k++) begin
      if (k == cut_after) begin
        if (cut_kind == 0) wr(5'h15, 8'h99);
        else               rd(5'h16, d);
      end
      rd(a[k], d);
    end
    if (cut_after == 5) rd(5'h16, d);
    rd(last, d);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    int n;
    logic [DW-1:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 busy", busy, 0);
    check("R1 busy_n", busy_n, 1);
    verify("R1 zero", 3);

    // R2: plain write and read sweep
    fill(0);
    verify("R2 pattern A", 0);

    // R3: power-down store
    pulse(1'b1, 1'b0, n);
    check("R3 store length", n, SCYC);
    fill(1);
    verify("R2 pattern B", 1);

    // R4: power-up recall, twice to show the shadow is untouched
    pulse(1'b0, 1'b1, n);
    check("R4 recall length", n, RCYC);
    verify("R4 recall A", 0);
    fill(1);
    pulse(1'b0, 1'b1, n);
    verify("R4 shadow kept A", 0);

    // R6 + R10: pin store, with blocked write and dropped power-up
    fill(1);
    store_n = 1'b0;
    n = 0;
    for (int k = 0; k < SCYC + 6; k++) begin
      @(negedge clk);
      if (busy) n++;
      if (k == 0) begin
        ce_n = 1'b0; we_n = 1'b0; addr = 5'd3; drv = 1'b1; dval = 8'h55;
        pwr_up = 1'b1;
      end else if (k == 1) begin
        ce_n = 1'b1; we_n = 1'b1; drv = 1'b0; pwr_up = 1'b0;
      end
    end
    check("R6 pin store length, no retrigger", n, SCYC);
    check("R10 no dropped recall", busy, 0);
    store_n = 1'b1;
    @(negedge clk);
    rd(3, d);
    check("R10 write ignored while busy", d, pat(1, 3));

    // R8: software recall
    fill(2);
    seq(5'h0C, 9, 0);
    busy_len(n);
    check("R8 sw recall length", n, RCYC);
    verify("R8 sw recall B", 1);

    // R7: software store
    fill(2);
    seq(5'h1F, 9, 0);
    busy_len(n);
    check("R7 sw store length", n, SCYC);
    fill(0);
    pulse(1'b0, 1'b1, n);
    verify("R7 stored C", 2);

    // R9: interrupted sequences trigger nothing
    seq(5'h1F, 3, 0);
    repeat (3) @(negedge clk);
    check("R9 write abort", busy, 0);
    seq(5'h1F, 4, 1);
    repeat (3) @(negedge clk);
    check("R9 stray read abort", busy, 0);
    seq(5'h0C, 5, 1);
    repeat (3) @(negedge clk);
    check("R9 stray read before last", busy, 0);
    fill(0);
    seq(5'h0C, 9, 0);
    busy_len(n);
    check("R9 full sequence after abort", n, RCYC);
    verify("R9 recall C", 2);

    // R5 + R11: power-down at edge 6 of a recall; words 0..3 loaded, rest cleared
    fill(0);
    pwr_up = 1'b1;
    @(negedge clk);
    pwr_up = 1'b0;
    repeat (5) @(negedge clk);
    pwr_dn = 1'b1;
    @(negedge clk);
    pwr_dn = 1'b0;
    busy_len(n);
    check("R11 preempted store length", n, SCYC);
    for (int i = 0; i < DEPTH; i++) begin
      rd(i, d);
      check("R5 clear then load", d, (i < 4) ? pat(2, i) : 0);
    end
    fill(0);
    pulse(1'b0, 1'b1, n);
    for (int i = 0; i < DEPTH; i++) begin
      rd(i, d);
      check("R11 partial array stored", d, (i < 4) ? pat(2, i) : 0);
    end

    // R12: simultaneous events, store wins
    fill(1);
    pulse(1'b1, 1'b1, n);
    check("R12 store chosen", n, SCYC);
    fill(2);
    pulse(1'b0, 1'b1, n);
    verify("R12 stored B", 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule